// File: doc/BRIEF.md
# Biphase-Mark Audio Sub-frame Transmitter

This block turns a stream of two-channel audio words into a single serial line that follows the IEC 60958 sub-frame layout. Each sub-frame is 32 time slots long. Slots 0 to 3 carry a sync preamble. Slots 4 to 27 carry the sample field. Slots 28, 29 and 30 carry the validity, user and channel-status bits, and slot 31 carries parity. Every slot is two half-bit cells wide, so a sub-frame lasts 64 half-bit cells. The line moves only on cycles where the clock enable `half_en` is high, and that enable is expected at twice the bit rate.

Words are taken one per sub-frame through a ready/valid handshake. The output `req_right` tells the source which channel the next accepted word will fill. The sub-frames alternate left, right, left, and so on, starting with left. If the source has no word ready when the handshake opens, the previous field, user bit and channel-status bit go out again, and the validity bit is forced high. The `in_nonpcm` input selects, per word, between a 24-bit audio field and a 16-bit non-PCM data field.

Top module: `spdif_bmc_tx`

## Requirements
- R1: The preamble is 8 half-bit cells. With a line level of 0 before the sub-frame, B = 11101000, M = 11100010 and W = 11100100, sent leftmost first. With a level of 1 before the sub-frame, each pattern is inverted. The first preamble cell therefore always toggles the line.
- R2: The first left sub-frame after reset, and every 192nd left sub-frame after it, uses B. Every other left sub-frame uses M. Every right sub-frame uses W.
- R3: Slots 4 to 31 use biphase mark coding. The line toggles at the start of every slot. For a 1 it toggles again at mid-slot, and for a 0 it holds at mid-slot.
- R4: In audio mode (`in_nonpcm`=0), `in_sample` bit i goes in slot 4+i, so the field is sent LSB first and bit 23 lands in slot 27. A narrower sample is supplied left-justified.
- R5: Slot 28 carries validity, slot 29 carries user data and slot 30 carries channel status, all taken from the accepted word.
- R6: Slot 31 is chosen so that slots 4 to 31 carry an even number of ones.
- R7: In non-PCM mode (`in_nonpcm`=1), `in_sample[15:0]` goes in slots 12 (LSB) to 27 (MSB), and slots 4 to 11 are 0.
- R8: `in_ready` is high only in the cycle where `half_en` is high and the last half-bit cell of a sub-frame is on the line. That is exactly once per sub-frame. The word is taken on that edge when `in_valid` is high.
- R9: If `in_valid` is low while `in_ready` is high, the next sub-frame repeats the previous field, user bit and channel-status bit, with validity set to 1.
- R10: `line_out` changes only on clock edges where `half_en` is high.
- R11: During and right after reset, `line_out` is 0, `in_ready` is 0 while `half_en` is low, and `req_right` is 0. The held word is all zeros.
- R12: `req_right` gives the channel of the next sub-frame (0 = left) and flips at every sub-frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_en | input | 1 | Clock enable at the half-bit-cell rate |
| in_valid | input | 1 | Source has a word to offer |
| in_ready | output | 1 | Word is taken on this edge when in_valid is high |
| in_sample | input | 24 | Audio sample, or non-PCM payload in bits 15:0 |
| in_validity | input | 1 | Validity bit for the word |
| in_user | input | 1 | User data bit for the word |
| in_cstat | input | 1 | Channel-status bit for the word |
| in_nonpcm | input | 1 | 1 selects the 16-bit non-PCM placement |
| req_right | output | 1 | Channel of the next sub-frame, 1 = right |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
The bench decodes every sub-frame from the line. It checks the preamble against the level the line held before the sub-frame, so a design that ignored the prior level would send a pattern of the wrong polarity and break the line's transition rhythm. The run covers more than 192 frames, so the B pattern has to come back after exactly one block; an off-by-one in the frame count would show B early or late. Random gaps in `in_valid` exercise the repeat path: a design that dropped the held field or left validity low would be caught. Switching into non-PCM mode catches a field placed at slot 4 instead of slot 12, and the parity check catches an odd-parity or wrong-span parity bit.

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx #(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        half_en,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [23:0] in_sample,
  input  logic        in_validity,
  input  logic        in_user,
  input  logic        in_cstat,
  input  logic        in_nonpcm,
  output logic        req_right,
  output logic        line_out
);
  localparam int FW = $clog2(FRAMES_PER_BLOCK);
  localparam logic [1:0] PT_B = 2'd0, PT_M = 2'd1, PT_W = 2'd2;

  logic [5:0]    hcnt;
  logic          right_q;
  logic [FW-1:0] fcnt;
  logic [27:0]   word;
  logic [1:0]    ptype;
  logic          pre_pol;
  logic          line_q;
  logic [23:0]   hold_field;
  logic          hold_u, hold_cs;

  wire wrap = (hcnt == 6'd63);
  assign in_ready  = half_en & wrap;
  assign req_right = ~right_q;
  assign line_out  = line_q;

  wire        take      = in_ready & in_valid;
  wire [23:0] new_field = in_nonpcm ? {in_sample[15:0], 8'h00} : in_sample;
  wire [23:0] fld       = take ? new_field : hold_field;
  wire        bit_v     = take ? in_validity : 1'b1;
  wire        bit_u     = take ? in_user : hold_u;
  wire        bit_cs    = take ? in_cstat : hold_cs;
  wire [26:0] body      = {bit_cs, bit_u, bit_v, fld};
  wire [27:0] next_word = {^body, body};

  wire [FW-1:0] fcnt_inc = (fcnt == FW'(FRAMES_PER_BLOCK - 1)) ? '0 : fcnt + 1'b1;
  wire [1:0]    next_type = right_q ? ((fcnt_inc == '0) ? PT_B : PT_M) : PT_W;

  wire [5:0] k_next = wrap ? 6'd0 : hcnt + 6'd1;
  wire [4:0] sidx   = k_next[5:1] - 5'd4;

  function automatic logic [7:0] pattern(input logic [1:0] t);
    case (t)
      PT_B:    pattern = 8'b1110_1000;
      PT_M:    pattern = 8'b1110_0010;
      default: pattern = 8'b1110_0100;
    endcase
  endfunction

  logic [7:0] pat;
  logic       lvl;
  always_comb begin
    pat = pattern(ptype);
    if (k_next == 6'd0)       lvl = ~line_q;
    else if (k_next < 6'd8)   lvl = pat[3'd7 - k_next[2:0]] ^ pre_pol;
    else if (!k_next[0])      lvl = ~line_q;
    else                      lvl = line_q ^ word[sidx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt       <= 6'd63;
      right_q    <= 1'b1;
      fcnt       <= FW'(FRAMES_PER_BLOCK - 1);
      word       <= '0;
      ptype      <= PT_B;
      pre_pol    <= 1'b0;
      line_q     <= 1'b0;
      hold_field <= '0;
      hold_u     <= 1'b0;
      hold_cs    <= 1'b0;
    end else if (half_en) begin
      hcnt   <= k_next;
      line_q <= lvl;
      if (wrap) begin
        right_q <= ~right_q;
        if (right_q) fcnt <= fcnt_inc;
        word    <= next_word;
        ptype   <= next_type;
        pre_pol <= line_q;
        if (take) begin
          hold_field <= new_field;
          hold_u     <= in_user;
          hold_cs    <= in_cstat;
        end
      end
    end
  end
endmodule

// File: rtl/spdif_bmc_tx_chk.sv
module spdif_bmc_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       half_en,
  input logic       in_ready,
  input logic       req_right,
  input logic       line_out,
  input logic [5:0] hcnt
);
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !half_en |=> $stable(line_out)); // R10
  AST_PREAMBLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && hcnt == 6'd63) |=> line_out != $past(line_out)); // R1
  AST_SLOT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && hcnt[0] && hcnt >= 6'd7 && hcnt != 6'd63) |=> line_out != $past(line_out)); // R3
  AST_READY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> (hcnt == 6'd0) && !in_ready); // R8
  AST_CHAN_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && hcnt == 6'd63) |=> req_right != $past(req_right)); // R12
endmodule

bind spdif_bmc_tx spdif_bmc_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .in_ready(in_ready),
  .req_right(req_right), .line_out(line_out), .hcnt(hcnt)
);

// File: tb/spdif_bmc_tx_tb.sv
module spdif_bmc_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSUB = 800;

  logic clk = 0, rst_n = 0, half_en = 0, in_valid = 0;
  logic [23:0] in_sample = 0;
  logic in_validity = 0, in_user = 0, in_cstat = 0, in_nonpcm = 0;
  logic in_ready, req_right, line_out;

  spdif_bmc_tx u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] build(input logic [23:0] f, input logic v, input logic u, input logic cs);
    logic [26:0] b;
    b = {cs, u, v, f};
    return {^b, b};
  endfunction

  function automatic logic [7:0] pat_of(input int t);
    return t == 0 ? 8'b11101000 : (t == 1 ? 8'b11100010 : 8'b11100100);
  endfunction

  logic cells [64];
  logic [27:0] exp_word;
  int exp_type;
  logic exp_prev;
  bit exp_np, started;

  task automatic check_sub();
    logic [7:0] p, got;
    logic lv, a, b;
    logic [27:0] w;
    bit edges_ok;
    p = pat_of(exp_type) ^ {8{exp_prev}};
    for (int i = 0; i < 8; i++) got[7-i] = cells[i];
    chk(got == p, exp_type == 0 ? "R1/R2 B preamble" : (exp_type == 1 ? "R1/R2 M preamble" : "R1/R2 W preamble"), got, p);
    lv = cells[7];
    edges_ok = 1;
    for (int s = 0; s < 28; s++) begin
      a = cells[8+2*s]; b = cells[9+2*s];
      if (a == lv) edges_ok = 0;
      w[s] = a ^ b;
      lv = b;
    end
    chk(edges_ok, "R3 slot boundary transitions", edges_ok, 1);
    if (exp_np) begin
      chk(w[7:0] == 8'h00, "R7 slots 4-11 zero", w[7:0], 0);
      chk(w[23:8] == exp_word[23:8], "R7 non-PCM payload", w[23:8], exp_word[23:8]);
    end else
      chk(w[23:0] == exp_word[23:0], "R4 audio field LSB first", w[23:0], exp_word[23:0]);
    chk(w[26:24] == exp_word[26:24], "R5/R9 validity user status", w[26:24], exp_word[26:24]);
    chk(w[27] == exp_word[27] && ^w == 1'b0, "R6 even parity", w[27], exp_word[27]);
  endtask

  initial begin
    int k, nsub, bfr;
    bit m_right, en_q, en;
    logic last_line;
    logic [23:0] m_field;
    logic m_u, m_cs, v;
    k = 63; nsub = 0; bfr = 191; m_right = 1; en_q = 0;
    m_field = 0; m_u = 0; m_cs = 0; started = 0;
    repeat (3) @(negedge clk);
    chk(line_out == 0, "R11 line low in reset", line_out, 0);
    chk(req_right == 0, "R11 first request left", req_right, 0);
    chk(in_ready == 0, "R11 ready low", in_ready, 0);
    rst_n = 1;
    last_line = 0;
    while (nsub < NSUB + 1) begin
      @(negedge clk);
      if (en_q) begin
        k = (k == 63) ? 0 : k + 1;
        cells[k] = line_out;
        if (k == 63 && started) check_sub();
      end else
        chk(line_out == last_line, "R10 line held without enable", line_out, last_line);
      last_line = line_out;
      en = ($urandom % 4) != 0;
      half_en = en;
      in_nonpcm = (nsub >= 500);
      in_valid = (nsub < 4) ? 1'b1 : (nsub % 37 == 5 || nsub % 37 == 6) ? 1'b0 : (($urandom % 8) != 0);
      if (nsub == 1) in_sample = 24'hFFFFFF;
      else if (nsub == 2) in_sample = 24'h000000;
      else if (nsub == 3) in_sample = 24'h800001;
      else in_sample = $urandom;
      in_validity = $urandom; in_user = $urandom; in_cstat = $urandom;
      #1;
      chk(in_ready == (en && k == 63), "R8 ready timing", in_ready, en && k == 63);
      if (in_ready) begin
        chk(req_right == !m_right, "R12 channel request", req_right, !m_right);
        m_right = !m_right;
        if (!m_right) bfr = (bfr == 191) ? 0 : bfr + 1;
        exp_type = m_right ? 2 : (bfr == 0 ? 0 : 1);
        if (in_valid) begin
          m_field = in_nonpcm ? {in_sample[15:0], 8'h00} : in_sample;
          m_u = in_user; m_cs = in_cstat; v = in_validity;
        end else v = 1'b1;
        exp_word = build(m_field, v, m_u, m_cs);
        exp_np = in_nonpcm;
        exp_prev = line_out;
        started = 1;
        nsub++;
      end
      en_q = en;
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule